// File: doc/BRIEF.md
# Cache Read Column Generator

This block sits between the serial command front-end of a page-buffered flash device and its page cache. When a frame opens with one of the two cache-read opcodes, it takes the next two bytes as a column address and discards the byte after them. It then supplies one cache column per data byte that the output shifter asks for. The upper four bits of the first address byte select a wrap length. The column sequence either runs through the whole page and returns to column 0, or circles inside an aligned window of 64 or 16 bytes.

The page holds 2112 bytes, but the column field is 12 bits wide. A starting column beyond the last real byte marks the read as out of range. For the rest of that frame the address stays put and every data byte is forced to FFh. The front-end presents bytes with a one-cycle strobe. A level input that is high while the device is selected frames each command. Dropping that level ends the read at once.

Top module: `cache_rd_addr_gen`

## Requirements
- R1: After reset, `addr_valid` and `out_of_range` are 0 and `cache_addr` is 0.
- R2: The first byte of a frame is an opcode. Only 03h and 0Bh start a read. Any other opcode keeps `addr_valid` low, and `cache_addr` unchanged, until the frame ends.
- R3: After the opcode come a first address byte and a second address byte, then one dummy byte. In the cycle after the dummy byte is strobed, `addr_valid` is 1 and `cache_addr` is {first[3:0], second[7:0]}.
- R4: While `addr_valid` is 1, each cycle with `byte_req` high moves `cache_addr` to the next column in the following cycle. Without `byte_req`, `cache_addr` holds.
- R5: The wrap selector is first[7:4]. Selector 0, and every code not listed in R6 to R8, runs columns up to 2111 and then returns to 0.
- R6: Selector 4 returns to 0 after column 2047, and also after 2111 when it starts above 2047.
- R7: Selector 8 keeps bits 11:6 fixed and steps bits 5:0 modulo 64, so the column returns to the start of its aligned 64-byte window.
- R8: Selector 12 keeps bits 11:4 fixed and steps bits 3:0 modulo 16.
- R9: A starting column above 2111 sets `out_of_range` together with `addr_valid`. `cache_addr` then stays at the starting column whatever `byte_req` does, and `data_out` is FFh.
- R10: When `out_of_range` is 0, `data_out` equals `cache_rd_data`.
- R11: In a cycle with `cs_active` low, the block returns to waiting for an opcode. `addr_valid` and `out_of_range` are 0 in the next cycle and `cache_addr` keeps its value. This wins over a `byte_req` in the same cycle.
- R12: `byte_valid` strobes after the dummy byte have no effect on `cache_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_active | input | 1 | High while the device is selected; frames a command |
| byte_valid | input | 1 | One-cycle strobe for a received command byte |
| byte_data | input | 8 | Received command byte |
| byte_req | input | 1 | Output shifter asks for the next data byte |
| cache_rd_data | input | 8 | Byte read from the cache at `cache_addr` |
| cache_addr | output | 12 | Cache column being read |
| addr_valid | output | 1 | A read is in its data phase |
| out_of_range | output | 1 | Starting column lies beyond the page |
| data_out | output | 8 | Byte for the output shifter |

## Verification
Two things can land on the same clock edge: the end of a frame and a request for the next byte. The bench drops `cs_active` in the very cycle that `byte_req` is raised during a data phase. One cycle later it expects `addr_valid` low and the column unchanged. A second clash comes at a wrap point, where the increment and the return to the window start meet. Table vectors start one or two columns before each boundary, and the bench compares the final column with values worked out by hand.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam int COL_W = 12;
  localparam int SEL_W = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    WM_PAGE   = 2'd0,
    WM_MAIN   = 2'd1,
    WM_WIDE   = 2'd2,
    WM_NARROW = 2'd3
  } wrap_mode_e;

  typedef enum logic [2:0] {
    ST_OPCODE = 3'd0,
    ST_ADDR_HI = 3'd1,
    ST_ADDR_LO = 3'd2,
    ST_DUMMY  = 3'd3,
    ST_STREAM = 3'd4,
    ST_SKIP   = 3'd5
  } frame_state_e;
endpackage

// File: rtl/cr_frame_seq.sv
module cr_frame_seq
  import cr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] OPC_PLAIN = 8'h03,
  parameter logic [BYTE_W-1:0] OPC_FAST  = 8'h0B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              load_start,
  output logic              in_stream,
  output logic [SEL_W-1:0]  wrap_sel,
  output logic [COL_W-1:0]  col_start
);
  localparam int HI_COL_BITS = COL_W - BYTE_W;

  frame_state_e state_q, state_d;
  logic [BYTE_W-1:0] hi_q, lo_q;
  logic hi_en, lo_en;

  // next-state logic
  always_comb begin
    state_d    = state_q;
    hi_en      = 1'b0;
    lo_en      = 1'b0;
    load_start = 1'b0;
    if (!cs_active) begin
      state_d = ST_OPCODE;
    end else if (byte_valid) begin
      unique case (state_q)
        ST_OPCODE: begin
          if (byte_data == OPC_PLAIN || byte_data == OPC_FAST) state_d = ST_ADDR_HI;
          else state_d = ST_SKIP;
        end
        ST_ADDR_HI: begin
          hi_en   = 1'b1;
          state_d = ST_ADDR_LO;
        end
        ST_ADDR_LO: begin
          lo_en   = 1'b1;
          state_d = ST_DUMMY;
        end
        ST_DUMMY: begin
          load_start = 1'b1;
          state_d    = ST_STREAM;
        end
        ST_STREAM: state_d = ST_STREAM;
        ST_SKIP:   state_d = ST_SKIP;
        default:   state_d = ST_OPCODE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPCODE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= byte_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= byte_data;
    end
  end

  assign in_stream = (state_q == ST_STREAM);
  assign wrap_sel  = hi_q[BYTE_W-1 -: SEL_W];
  assign col_start = {hi_q[HI_COL_BITS-1:0], lo_q};
endmodule

// File: rtl/cr_wrap_decode.sv
module cr_wrap_decode
  import cr_pkg::*;
#(
  parameter logic [SEL_W-1:0] SEL_MAIN   = 4'd4,
  parameter logic [SEL_W-1:0] SEL_WIDE   = 4'd8,
  parameter logic [SEL_W-1:0] SEL_NARROW = 4'd12
) (
  input  logic [SEL_W-1:0] wrap_sel,
  output wrap_mode_e       wrap_mode
);
  always_comb begin
    if (wrap_sel == SEL_MAIN)        wrap_mode = WM_MAIN;
    else if (wrap_sel == SEL_WIDE)   wrap_mode = WM_WIDE;
    else if (wrap_sel == SEL_NARROW) wrap_mode = WM_NARROW;
    else                             wrap_mode = WM_PAGE;
  end
endmodule

// File: rtl/cr_col_stepper.sv
module cr_col_stepper
  import cr_pkg::*;
#(
  parameter int PAGE_COLS  = 2112,
  parameter int MAIN_COLS  = 2048,
  parameter int WIN_WIDE   = 64,
  parameter int WIN_NARROW = 16
) (
  input  logic [COL_W-1:0] cur_col,
  input  wrap_mode_e       wrap_mode,
  output logic [COL_W-1:0] next_col
);
  localparam logic [COL_W-1:0] PAGE_LAST = COL_W'(PAGE_COLS - 1);
  localparam logic [COL_W-1:0] MAIN_LAST = COL_W'(MAIN_COLS - 1);
  localparam int N_WIN = 2;

  logic [COL_W-1:0] seq_inc;
  logic [COL_W-1:0] win_next [N_WIN];

  assign seq_inc = cur_col + COL_W'(1);

  // window steppers: index 0 is the wide window, index 1 the narrow one
  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    localparam int LEN = (g == 0) ? WIN_WIDE : WIN_NARROW;
    localparam int LB  = $clog2(LEN);
    logic [LB-1:0] low_inc;
    assign low_inc     = cur_col[LB-1:0] + LB'(1);
    assign win_next[g] = {cur_col[COL_W-1:LB], low_inc};
  end

  always_comb begin
    unique case (wrap_mode)
      WM_MAIN:   next_col = (cur_col == MAIN_LAST || cur_col == PAGE_LAST) ? '0 : seq_inc;
      WM_WIDE:   next_col = win_next[0];
      WM_NARROW: next_col = win_next[1];
      default:   next_col = (cur_col == PAGE_LAST) ? '0 : seq_inc;
    endcase
  end
endmodule

// File: rtl/cache_rd_addr_gen.sv
module cache_rd_addr_gen
  import cr_pkg::*;
#(
  parameter int PAGE_COLS  = 2112,
  parameter int MAIN_COLS  = 2048,
  parameter int WIN_WIDE   = 64,
  parameter int WIN_NARROW = 16,
  parameter logic [BYTE_W-1:0] OPC_PLAIN = 8'h03,
  parameter logic [BYTE_W-1:0] OPC_FAST  = 8'h0B,
  parameter logic [BYTE_W-1:0] FILL_BYTE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              byte_req,
  input  logic [7:0]        cache_rd_data,
  output logic [11:0]       cache_addr,
  output logic              addr_valid,
  output logic              out_of_range,
  output logic [7:0]        data_out
);
  localparam logic [COL_W-1:0] PAGE_LAST = COL_W'(PAGE_COLS - 1);

  logic             load_start, in_stream;
  logic [SEL_W-1:0] wrap_sel;
  logic [COL_W-1:0] col_start, next_col;
  wrap_mode_e       dec_mode, mode_q, mode_d;
  logic [COL_W-1:0] addr_q, addr_d;
  logic             oor_q, oor_d;
  logic             addr_en, mode_en;

  cr_frame_seq #(.OPC_PLAIN(OPC_PLAIN), .OPC_FAST(OPC_FAST)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_active  (cs_active),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .load_start (load_start),
    .in_stream  (in_stream),
    .wrap_sel   (wrap_sel),
    .col_start  (col_start)
  );

  cr_wrap_decode u_dec (
    .wrap_sel  (wrap_sel),
    .wrap_mode (dec_mode)
  );

  cr_col_stepper #(
    .PAGE_COLS  (PAGE_COLS),
    .MAIN_COLS  (MAIN_COLS),
    .WIN_WIDE   (WIN_WIDE),
    .WIN_NARROW (WIN_NARROW)
  ) u_step (
    .cur_col   (addr_q),
    .wrap_mode (mode_q),
    .next_col  (next_col)
  );

  // next-state logic
  always_comb begin
    addr_d  = addr_q;
    oor_d   = oor_q;
    mode_d  = mode_q;
    addr_en = 1'b0;
    mode_en = 1'b0;
    if (!cs_active) begin
      oor_d = 1'b0;
    end else if (load_start) begin
      addr_d  = col_start;
      addr_en = 1'b1;
      mode_d  = dec_mode;
      mode_en = 1'b1;
      oor_d   = (col_start > PAGE_LAST);
    end else if (in_stream && byte_req && !oor_q) begin
      addr_d  = next_col;
      addr_en = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WM_PAGE;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oor_q <= 1'b0;
    end else begin
      oor_q <= oor_d;
    end
  end

  assign cache_addr   = addr_q;
  assign addr_valid   = in_stream;
  assign out_of_range = oor_q;
  assign data_out     = oor_q ? FILL_BYTE : cache_rd_data;
endmodule

// File: rtl/cache_rd_addr_chk.sv
module cache_rd_addr_chk
  import cr_pkg::*;
#(
  parameter int PAGE_COLS  = 2112,
  parameter int WIN_WIDE   = 64,
  parameter int WIN_NARROW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_active,
  input logic             byte_req,
  input logic             addr_valid,
  input logic             out_of_range,
  input logic [COL_W-1:0] cache_addr,
  input wrap_mode_e       wrap_mode
);
  localparam int WB = $clog2(WIN_WIDE);
  localparam int NB = $clog2(WIN_NARROW);

  // R11
  frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (!addr_valid && !out_of_range));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && cs_active && !byte_req) |=> $stable(cache_addr));

  // R9
  oor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_of_range && cs_active && byte_req) |=> $stable(cache_addr));

  // R5
  in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !out_of_range) |-> (cache_addr < COL_W'(PAGE_COLS)));

  // R7
  wide_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && cs_active && byte_req && !out_of_range && wrap_mode == WM_WIDE)
      |=> (cache_addr[COL_W-1:WB] == $past(cache_addr[COL_W-1:WB])));

  // R8
  narrow_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && cs_active && byte_req && !out_of_range && wrap_mode == WM_NARROW)
      |=> (cache_addr[COL_W-1:NB] == $past(cache_addr[COL_W-1:NB])));
endmodule

bind cache_rd_addr_gen cache_rd_addr_chk #(
  .PAGE_COLS  (PAGE_COLS),
  .WIN_WIDE   (WIN_WIDE),
  .WIN_NARROW (WIN_NARROW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_active    (cs_active),
  .byte_req     (byte_req),
  .addr_valid   (addr_valid),
  .out_of_range (out_of_range),
  .cache_addr   (cache_addr),
  .wrap_mode    (mode_q)
);

// File: tb/cache_rd_addr_gen_test.sv
module cache_rd_addr_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_active = 1'b0;
  logic byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic byte_req = 1'b0;
  logic [7:0] cache_rd_data;
  logic [11:0] cache_addr;
  logic addr_valid, out_of_range;
  logic [7:0] data_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  // cache model: data depends only on the column
  assign cache_rd_data = cache_addr[7:0] ^ 8'h3C;

  cache_rd_addr_gen uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_active     (cs_active),
    .byte_valid    (byte_valid),
    .byte_data     (byte_data),
    .byte_req      (byte_req),
    .cache_rd_data (cache_rd_data),
    .cache_addr    (cache_addr),
    .addr_valid    (addr_valid),
    .out_of_range  (out_of_range),
    .data_out      (data_out)
  );

  // {opcode, first addr byte, second addr byte, requests, expected column, expected oor}
  localparam logic [44:0] VEC [0:10] = '{
    {8'h03, 8'h00, 8'h10, 8'd5,  12'h015, 1'b0},  // R3 R4 plain stepping
    {8'h0B, 8'h08, 8'h2E, 8'd20, 12'h002, 1'b0},  // R5 page wrap from 2094
    {8'h03, 8'h47, 8'hFE, 8'd3,  12'h001, 1'b0},  // R6 main wrap from 2046
    {8'h03, 8'h88, 8'h3E, 8'd3,  12'h801, 1'b0},  // R7 last 64-byte window
    {8'h0B, 8'hC0, 8'h1D, 8'd4,  12'h011, 1'b0},  // R8 16-byte window
    {8'h03, 8'h18, 8'h40, 8'd3,  12'h840, 1'b1},  // R9 column 2112
    {8'h03, 8'h28, 8'h3F, 8'd1,  12'h000, 1'b0},  // R5 unlisted selector
    {8'h0B, 8'h48, 8'h3F, 8'd1,  12'h000, 1'b0},  // R6 start above 2047
    {8'h03, 8'hFF, 8'hFF, 8'd2,  12'hFFF, 1'b1},  // R9 column 4095
    {8'h0B, 8'hC8, 8'h3F, 8'd2,  12'h831, 1'b0},  // R8 narrow window at page end
    {8'h03, 8'h80, 8'h00, 8'd64, 12'h000, 1'b0}   // R7 full lap of a window
  };

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog act %0d exp below 150000", cycles);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    byte_valid = 1'b1;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic open_frame();
    cs_active = 1'b1;
    @(negedge clk);
  endtask

  task automatic close_frame();
    cs_active = 1'b0;
    byte_req  = 1'b0;
    @(negedge clk);
  endtask

  task automatic requests(input int n);
    for (int k = 0; k < n; k++) begin
      byte_req = 1'b1;
      @(negedge clk);
    end
    byte_req = 1'b0;
  endtask

  initial begin
    logic [11:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(addr_valid), 32'd0);
    chk("R1 oor", 32'(out_of_range), 32'd0);
    chk("R1 addr", 32'(cache_addr), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 11; i++) begin
      logic [44:0] v;
      v = VEC[i];
      open_frame();
      send_byte(v[44:37]);
      send_byte(v[36:29]);
      send_byte(v[28:21]);
      chk("R3 not yet valid", 32'(addr_valid), 32'd0);
      send_byte(8'h00);
      chk("R3 valid after dummy", 32'(addr_valid), 32'd1);
      chk("R3 start column", 32'(cache_addr), 32'({v[32:29], v[28:21]}));
      chk("R9 oor flag", 32'(out_of_range), 32'(v[0]));
      requests(int'(v[20:13]));
      @(negedge clk);
      chk("R4 R5 R6 R7 R8 R9 final column", 32'(cache_addr), 32'(v[12:1]));
      chk("R9 R10 data", 32'(data_out), v[0] ? 32'h0FF : 32'(v[8:1] ^ 8'h3C));
      close_frame();
      chk("R11 valid after frame", 32'(addr_valid), 32'd0);
      chk("R11 oor after frame", 32'(out_of_range), 32'd0);
    end

    // R2 unknown opcode never starts a read
    held = cache_addr;
    open_frame();
    send_byte(8'h6B);
    send_byte(8'h01);
    send_byte(8'h23);
    send_byte(8'h00);
    send_byte(8'h00);
    requests(2);
    chk("R2 no valid", 32'(addr_valid), 32'd0);
    chk("R2 addr untouched", 32'(cache_addr), 32'(held));
    close_frame();

    // R12 stray bytes during data phase
    open_frame();
    send_byte(8'h03);
    send_byte(8'h01);
    send_byte(8'h00);
    send_byte(8'h00);
    requests(2);
    chk("R4 column", 32'(cache_addr), 32'h102);
    send_byte(8'hAA);
    send_byte(8'h03);
    chk("R12 column unchanged", 32'(cache_addr), 32'h102);
    chk("R12 still valid", 32'(addr_valid), 32'd1);
    chk("R10 data", 32'(data_out), 32'(8'h02 ^ 8'h3C));

    // R11 frame end and byte request in the same cycle
    byte_req  = 1'b1;
    cs_active = 1'b0;
    @(negedge clk);
    byte_req  = 1'b0;
    chk("R11 drop beats request valid", 32'(addr_valid), 32'd0);
    chk("R11 drop beats request column", 32'(cache_addr), 32'h102);

    // R9 out-of-range frame then a clean frame clears the flag
    open_frame();
    send_byte(8'h0B);
    send_byte(8'h09);
    send_byte(8'h00);
    send_byte(8'h00);
    chk("R9 oor set", 32'(out_of_range), 32'd1);
    close_frame();
    open_frame();
    send_byte(8'h03);
    send_byte(8'h00);
    send_byte(8'h07);
    send_byte(8'h00);
    chk("R9 oor cleared", 32'(out_of_range), 32'd0);
    chk("R10 data new frame", 32'(data_out), 32'(8'h07 ^ 8'h3C));
    close_frame();

    summary();
  end
endmodule